// File: doc/BRIEF.md
# Tag-Based Register Hazard Tracker

This block guards the operand reads of an in-order pipeline against read-after-write hazards. It does not model the pipeline stages. Each issued instruction that writes a register takes a 2-bit tag from a rotating counter. The block stores that tag against the destination register and marks the register as pending.

A later instruction that reads a pending register picks up the stored producer tag. It stalls at issue until a writeback carrying both that register and that tag arrives. There is no forwarding, so an operand becomes usable only when its value is written back. A writeback in the same cycle as the dependent issue releases the stall in that cycle.

When a register is written again before its first value returns, the newer tag replaces the older one. A late writeback that carries the stale tag then leaves the register pending. Issue also stalls while the next tag in rotation still belongs to an instruction that has not written back.

Top module: `reg_tag_tracker`

## Requirements
- R1: After reset, no register is pending, `iss_tag` is 0 and no tag is outstanding. An issue that reads any register does not stall.
- R2: When `iss_valid` is high and a valid source names a pending register, `stall` is high in the same cycle, unless R6 applies.
- R3: Each of the three source slots is checked on its own. Slot k is `iss_src[5k+4:5k]` and is enabled by `iss_src_vld[k]`. A slot whose enable is low has no effect on `stall`.
- R4: A writeback whose `wb_reg` and `wb_tag` match a pending register and its stored tag clears that register's pending state. From the next cycle, reads of that register do not stall.
- R5: A writeback whose tag differs from the tag stored for `wb_reg` leaves that register pending. This covers a register that a newer writer has re-tagged.
- R6: A matching writeback in the same cycle as a dependent issue removes that hazard in that cycle.
- R7: `iss_tag` shows the tag the next writing instruction receives. It advances by one modulo 4 on each issue with `iss_wr_en` high and `stall` low, and it holds otherwise. The issued destination becomes pending under that tag.
- R8: A writing issue stalls while its tag is still outstanding, meaning an earlier writer with that tag has not written back. A writeback of that tag in the same cycle frees it.
- R9: `stall` is low whenever `iss_valid` is low.
- R10: A stalled instruction records nothing. Its destination does not become pending and the tag does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_wr_en | input | 1 | The presented instruction writes a register |
| iss_dst | input | 5 | Destination register |
| iss_src_vld | input | 3 | Per-slot source enables |
| iss_src | input | 15 | Three packed source register numbers, slot 0 in the low bits |
| wb_valid | input | 1 | A writeback occurs this cycle |
| wb_tag | input | 2 | Tag of the writeback |
| wb_reg | input | 5 | Register being written back |
| stall | output | 1 | The presented instruction must not issue this cycle |
| iss_tag | output | 2 | Tag that the next writing instruction receives |

## Verification
Two situations are hard to reach from the ports: a stale writeback arriving for a register that a newer writer has re-tagged, and the point where all four tags are outstanding. For the first, the stimulus writes the same register twice in a row and then returns the older tag first. For the second, it issues four writers back to back and returns none of them, then frees a tag with a writeback in the same cycle as the blocked issue. A stalled writer is also presented, and the register it names is read afterwards to show that nothing was recorded.

// File: rtl/tht_pkg.sv
package tht_pkg;

  function automatic logic [1:0] tag_step(input logic [1:0] cur);
    return cur + 2'd1;
  endfunction

  function automatic logic wb_frees(input logic wv, input logic [4:0] wreg,
                                    input logic [1:0] wtag, input logic [4:0] rreg,
                                    input logic [1:0] rtag);
    return wv && (wreg == rreg) && (wtag == rtag);
  endfunction

endpackage

// File: rtl/tht_tag_pool.sv
module tht_tag_pool #(
  parameter int TAG_W = 2,
  localparam int NTAG = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  output logic [TAG_W-1:0] next_tag,
  output logic             next_busy,
  output logic [NTAG-1:0]  busy_vec
);

  always_ff @(posedge clk) begin
    if (!rst_n)      next_tag <= '0;
    else if (alloc)  next_tag <= next_tag + 1'b1;
  end

  for (genvar t = 0; t < NTAG; t++) begin : g_tag
    always_ff @(posedge clk) begin
      if (!rst_n)                                  busy_vec[t] <= 1'b0;
      else if (alloc && next_tag == TAG_W'(t))     busy_vec[t] <= 1'b1;
      else if (wb_valid && wb_tag == TAG_W'(t))    busy_vec[t] <= 1'b0;
    end
  end

  // a writeback of the same tag this cycle frees it for immediate reuse
  assign next_busy = busy_vec[next_tag] && !(wb_valid && wb_tag == next_tag);

endmodule

// File: rtl/tht_pend_table.sv
module tht_pend_table #(
  parameter int NREG  = 32,
  parameter int TAG_W = 2,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             wb_valid,
  input  logic [REG_W-1:0] wb_reg,
  input  logic [TAG_W-1:0] wb_tag,
  output logic [NREG-1:0]  pend_vec,
  output logic [TAG_W-1:0] tag_arr [NREG],
  output logic             wb_hit
);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic set_here, clr_here;
    assign set_here = set_en && (set_reg == REG_W'(r));
    assign clr_here = wb_valid && (wb_reg == REG_W'(r)) && pend_vec[r] &&
                      (tag_arr[r] == wb_tag);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_vec[r] <= 1'b0;
        tag_arr[r]  <= '0;
      end else if (set_here) begin
        pend_vec[r] <= 1'b1;
        tag_arr[r]  <= set_tag;
      end else if (clr_here) begin
        pend_vec[r] <= 1'b0;
      end
    end
  end

  assign wb_hit = wb_valid && pend_vec[wb_reg] && (tag_arr[wb_reg] == wb_tag);

endmodule

// File: rtl/tht_src_check.sv
module tht_src_check #(
  parameter int NREG  = 32,
  parameter int TAG_W = 2,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic             src_vld,
  input  logic [REG_W-1:0] src_reg,
  input  logic [NREG-1:0]  pend_vec,
  input  logic [TAG_W-1:0] tag_arr [NREG],
  input  logic             wb_valid,
  input  logic [REG_W-1:0] wb_reg,
  input  logic [TAG_W-1:0] wb_tag,
  output logic             hazard
);
  import tht_pkg::*;

  logic released;
  assign released = wb_frees(wb_valid, 5'(wb_reg), 2'(wb_tag), 5'(src_reg),
                             2'(tag_arr[src_reg]));
  assign hazard   = src_vld && pend_vec[src_reg] && !released;

endmodule

// File: rtl/reg_tag_tracker.sv
module reg_tag_tracker #(
  parameter int NREG  = 32,
  parameter int NSRC  = 3,
  parameter int TAG_W = 2,
  localparam int REG_W = $clog2(NREG),
  localparam int NTAG  = 1 << TAG_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  iss_valid,
  input  logic                  iss_wr_en,
  input  logic [REG_W-1:0]      iss_dst,
  input  logic [NSRC-1:0]       iss_src_vld,
  input  logic [NSRC*REG_W-1:0] iss_src,
  input  logic                  wb_valid,
  input  logic [TAG_W-1:0]      wb_tag,
  input  logic [REG_W-1:0]      wb_reg,
  output logic                  stall,
  output logic [TAG_W-1:0]      iss_tag
);

  logic [NREG-1:0]  pend_vec;
  logic [TAG_W-1:0] tag_arr [NREG];
  logic [NTAG-1:0]  busy_vec;
  logic [NSRC-1:0]  src_haz;
  logic             tag_haz;
  logic             next_busy;
  logic             fire_wr;
  logic             wb_hit;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    tht_src_check #(.NREG(NREG), .TAG_W(TAG_W)) u_chk (
      .src_vld  (iss_src_vld[k]),
      .src_reg  (iss_src[k*REG_W +: REG_W]),
      .pend_vec (pend_vec),
      .tag_arr  (tag_arr),
      .wb_valid (wb_valid),
      .wb_reg   (wb_reg),
      .wb_tag   (wb_tag),
      .hazard   (src_haz[k])
    );
  end

  assign tag_haz = iss_wr_en && next_busy;
  assign stall   = iss_valid && ((|src_haz) || tag_haz);
  assign fire_wr = iss_valid && iss_wr_en && !stall;

  tht_tag_pool #(.TAG_W(TAG_W)) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc     (fire_wr),
    .wb_valid  (wb_valid),
    .wb_tag    (wb_tag),
    .next_tag  (iss_tag),
    .next_busy (next_busy),
    .busy_vec  (busy_vec)
  );

  tht_pend_table #(.NREG(NREG), .TAG_W(TAG_W)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (fire_wr),
    .set_reg  (iss_dst),
    .set_tag  (iss_tag),
    .wb_valid (wb_valid),
    .wb_reg   (wb_reg),
    .wb_tag   (wb_tag),
    .pend_vec (pend_vec),
    .tag_arr  (tag_arr),
    .wb_hit   (wb_hit)
  );

endmodule

// File: rtl/tht_checker.sv
module tht_checker #(
  parameter int NREG  = 32,
  parameter int NSRC  = 3,
  parameter int TAG_W = 2,
  localparam int REG_W = $clog2(NREG),
  localparam int NTAG  = 1 << TAG_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  iss_valid,
  input logic                  iss_wr_en,
  input logic [REG_W-1:0]      iss_dst,
  input logic [NSRC-1:0]       iss_src_vld,
  input logic [NSRC*REG_W-1:0] iss_src,
  input logic                  wb_valid,
  input logic [REG_W-1:0]      wb_reg,
  input logic                  stall,
  input logic [TAG_W-1:0]      iss_tag,
  input logic                  fire_wr,
  input logic                  wb_hit,
  input logic [NREG-1:0]       pend_vec,
  input logic [NTAG-1:0]       busy_vec
);

  p_idle_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> !stall);

  p_src_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_src_vld[0] && pend_vec[iss_src[REG_W-1:0]] && !wb_valid) |-> stall);

  p_tag_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_wr |=> (iss_tag == TAG_W'($past(iss_tag) + 1'b1)));

  p_tag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_wr |=> $stable(iss_tag));

  p_record_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_wr |=> pend_vec[$past(iss_dst)]);

  p_wb_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_hit && !(fire_wr && iss_dst == wb_reg)) |=> !pend_vec[$past(wb_reg)]);

  p_full_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_wr_en && $countones(busy_vec) == NTAG && !wb_valid) |-> stall);

endmodule

bind reg_tag_tracker tht_checker #(.NREG(NREG), .NSRC(NSRC), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_wr_en(iss_wr_en),
  .iss_dst(iss_dst), .iss_src_vld(iss_src_vld), .iss_src(iss_src),
  .wb_valid(wb_valid), .wb_reg(wb_reg), .stall(stall), .iss_tag(iss_tag),
  .fire_wr(fire_wr), .wb_hit(wb_hit), .pend_vec(pend_vec), .busy_vec(busy_vec)
);

// File: tb/sim_reg_tag_tracker.sv
module sim_reg_tag_tracker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid, iss_wr_en;
  logic [4:0]  iss_dst;
  logic [2:0]  iss_src_vld;
  logic [14:0] iss_src;
  logic        wb_valid;
  logic [1:0]  wb_tag;
  logic [4:0]  wb_reg;
  logic        stall;
  logic [1:0]  iss_tag;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  reg_tag_tracker u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_wr_en(iss_wr_en),
    .iss_dst(iss_dst), .iss_src_vld(iss_src_vld), .iss_src(iss_src),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_reg(wb_reg),
    .stall(stall), .iss_tag(iss_tag)
  );

  typedef struct packed {
    logic       iv;
    logic       wr;
    logic [4:0] dst;
    logic [2:0] sv;
    logic [4:0] s2, s1, s0;
    logic       wv;
    logic [1:0] wt;
    logic [4:0] wreg;
    logic       xstall;
    logic [1:0] xtag;
  } vec_t;

  localparam int NV = 26;
  // iv wr dst sv s2 s1 s0 wv wt wreg | stall tag
  localparam vec_t VEC [NV] = '{
    '{0,0, 0,0,0,0,0,0,0,0, 0,0},  // R1 idle after reset
    '{1,1, 5,0,0,0,0,0,0,0, 0,0},  // R7 r5 <- tag0
    '{1,0, 0,1,0,0,5,0,0,0, 1,1},  // R2 slot0 reads r5
    '{1,0, 0,2,0,5,0,0,0,0, 1,1},  // R3 slot1 reads r5
    '{1,0, 0,4,5,0,0,0,0,0, 1,1},  // R3 slot2 reads r5
    '{1,0, 0,0,5,5,5,0,0,0, 0,1},  // R3 all slots disabled
    '{1,0, 0,1,0,0,5,1,0,5, 0,1},  // R6 same-cycle wb tag0 r5
    '{1,0, 0,1,0,0,5,0,0,0, 0,1},  // R4 r5 now clear
    '{1,1, 7,0,0,0,0,0,0,0, 0,1},  // R7 r7 <- tag1
    '{1,1, 7,0,0,0,0,0,0,0, 0,2},  // R7 r7 <- tag2 (retag)
    '{1,0, 0,1,0,0,7,1,1,7, 1,3},  // R5 stale wb tag1
    '{1,0, 0,1,0,0,7,0,0,0, 1,3},  // R5 still pending
    '{1,0, 0,1,0,0,7,1,2,7, 0,3},  // R6 wb tag2 releases
    '{1,0, 0,1,0,0,7,0,0,0, 0,3},  // R4 r7 clear
    '{1,1, 1,0,0,0,0,0,0,0, 0,3},  // R7 r1 <- tag3
    '{1,1, 2,0,0,0,0,0,0,0, 0,0},  // R7 r2 <- tag0 (wrap)
    '{1,1, 3,0,0,0,0,0,0,0, 0,1},  // R7 r3 <- tag1
    '{1,1, 4,0,0,0,0,0,0,0, 0,2},  // R7 r4 <- tag2
    '{1,1, 6,0,0,0,0,0,0,0, 1,3},  // R8 tag3 outstanding
    '{1,1, 6,0,0,0,0,1,3,1, 0,3},  // R8 wb tag3 frees it
    '{1,0, 0,1,0,0,1,0,0,0, 0,0},  // R4 r1 clear
    '{1,0, 0,1,0,0,6,0,0,0, 1,0},  // R2 r6 pending tag3
    '{1,1, 9,1,0,0,2,0,0,0, 1,0},  // R10 writer stalled on r2
    '{1,0, 0,1,0,0,9,0,0,0, 0,0},  // R10 r9 not recorded
    '{1,1,10,0,0,0,0,0,0,0, 1,0},  // R8 tag0 still busy
    '{0,0, 0,1,0,0,6,0,0,0, 0,0}   // R9 no issue, no stall
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    iss_valid   = v.iv;
    iss_wr_en   = v.wr;
    iss_dst     = v.dst;
    iss_src_vld = v.sv;
    iss_src     = {v.s2, v.s1, v.s0};
    wb_valid    = v.wv;
    wb_tag      = v.wt;
    wb_reg      = v.wreg;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive('0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    check("R1 reset tag", iss_tag, 2'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #5;
      check($sformatf("R2-table stall row %0d", i), {1'b0, stall}, {1'b0, VEC[i].xstall});
      check($sformatf("R7 tag row %0d", i), iss_tag, VEC[i].xtag);
    end

    // R1: reset mid-run clears pending state and tag
    @(negedge clk);
    drive('0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive('{1,1,11,3,0,4,6,0,0,0,0,0});
    #5;
    check("R1 pending cleared by reset", {1'b0, stall}, 2'd0);
    check("R1 tag back to 0", iss_tag, 2'd0);
    @(negedge clk);
    drive('{1,0,0,1,0,0,11,0,0,0,0,0});
    #5;
    check("R7 r11 recorded after reset", {1'b0, stall}, 2'd1);
    check("R7 tag advanced", iss_tag, 2'd1);
    @(negedge clk);
    drive('{1,0,0,1,0,0,11,1,0,11,0,0});
    #5;
    check("R6 wb same cycle after reset", {1'b0, stall}, 2'd0);

    @(negedge clk);
    drive('0);
    finish_run();
  end

endmodule